// File: doc/BRIEF.md
# CAN Receive Record FIFO

This block is the receive store of a CAN controller. Each accepted frame is packed into a variable-length record and placed into a circular byte buffer. A record starts with an information byte carrying the frame format, the remote-request flag and the data length code. The identifier bytes come next, then the data bytes. The block tracks how many bytes and how many whole records it holds, and where the oldest record starts. The acceptance filter and the bit-level CAN engine sit upstream of this block and are not part of it.

A frame is offered on a valid/ready pair. The block writes the record into the buffer one byte per clock and holds ready low until the record is complete. The host reads the oldest record in place through a 13-byte address window. It frees that record with a release pulse, and the block works out the record's size from the stored information byte. If a frame would not fit, it is dropped whole and an overrun flag is raised. While the controller is held in its reset (configuration) mode nothing is stored. Returning to operating mode empties the buffer.

The asynchronous active-low reset is released to the logic through a two-flop synchroniser.

Top module: `canrx_record_fifo`

## Requirements
- R1: A standard-format record is laid out as: info byte, then ID[10:3], then {ID[2:0], 5'b0}, then the data bytes in order. The info byte is {ext, rtr, 2'b00, dlc[3:0]}, so bit 7 is the extended flag, bit 6 is RTR and bits 3..0 are the DLC.
- R2: An extended-format record is laid out as: info byte, then ID[28:21], ID[20:13], ID[12:5], {ID[4:0], 3'b0}, then the data bytes.
- R3: The record length is 3 bytes, plus 2 if extended, plus min(DLC, 8) data bytes unless RTR is set. A record with RTR set carries no data bytes. The stored DLC field keeps its raw value.
- R4: After a frame is accepted, the block writes one byte per clock. `rcv_busy` stays high and `frm_ready` stays low for exactly as many cycles as the record has bytes. The byte and message counts then rise by the record length and by one, in the same cycle that `rcv_busy` falls.
- R5: In operating mode, reading `host_addr` 16+k (k from 0 to 12) returns the buffer byte at (start + k) mod 64. Any other address, and any address in reset mode, reads 0x00.
- R6: A release pulse with at least one stored record moves the start pointer forward by the length decoded from the head info byte, modulo 64. The byte count drops by that length and the message count drops by one.
- R7: A release pulse while the message count is zero changes nothing.
- R8: `rx_sts` is set when a record is committed. It is cleared when a release brings the message count to zero. `irq` is the OR of `rx_sts` and `ovr_sts`.
- R9: If the byte count plus the new record length would exceed 64, the frame is discarded with no change to the counts or the buffer, and `ovr_sts` is set. A frame that makes the buffer exactly full is stored.
- R10: A `clr_ovr` pulse clears `ovr_sts`.
- R11: While `op_mode` is low, `frm_ready` is low and the counts do not change. When `op_mode` rises, both counts clear, `rx_sts` clears and the write pointer moves to the start pointer, so the next record appears at window offset 0.
- R12: After reset, the byte count, message count, `rx_sts`, `ovr_sts`, `rcv_busy` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 1 | 1 = operating mode, 0 = reset (configuration) mode |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Frame can be accepted this cycle |
| frm_ext | input | 1 | Extended identifier format |
| frm_rtr | input | 1 | Remote transmission request |
| frm_dlc | input | 4 | Data length code |
| frm_id | input | 29 | Identifier; a standard frame uses bits 10..0 |
| frm_data | input | 64 | Data bytes; byte i is on bits 8i+7..8i |
| rel_cmd | input | 1 | Release the oldest record (one-cycle pulse) |
| clr_ovr | input | 1 | Clear the overrun flag (one-cycle pulse) |
| host_addr | input | 5 | Host read address; 16..28 is the record window |
| host_rdata | output | 8 | Host read data (combinational) |
| byte_cnt | output | 7 | Bytes held |
| msg_cnt | output | 7 | Whole records held |
| rx_sts | output | 1 | Receive buffer holds at least one record |
| ovr_sts | output | 1 | Data overrun flag |
| rcv_busy | output | 1 | A record is being written |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a release pulse and a rising `op_mode` never fall in the same cycle. When they do coincide, the mode change wins and the release is dropped. They also assume that `frm_valid` is raised only when the sender respects `frm_ready`, and that the frame fields are stable in the accept cycle. The bench drives every input at the falling edge. It offers a frame only after seeing `frm_ready` high, and pulses release and the overrun clear in cycles where no mode change happens. The stimulus sweeps all 64 combinations of format, RTR and DLC, with releases mixed in, so the buffer wraps and overruns several times.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  localparam int REC_MAX  = 13;
  localparam int HDR_STD  = 3;
  localparam int HDR_EXT  = 5;
  localparam int DATA_MAX = 8;
  localparam int LENW     = $clog2(REC_MAX + 1);

  typedef logic [REC_MAX-1:0][7:0] rec_t;

  // Record size decoded from an information byte.
  function automatic logic [LENW-1:0] rec_len_f(input logic [7:0] info);
    logic [LENW-1:0] hdr;
    logic [LENW-1:0] nd;
    hdr = info[7] ? LENW'(HDR_EXT) : LENW'(HDR_STD);
    if (info[6])
      nd = '0;
    else if (info[3:0] > 4'(DATA_MAX))
      nd = LENW'(DATA_MAX);
    else
      nd = LENW'(info[3:0]);
    return hdr + nd;
  endfunction

endpackage

// File: rtl/canrx_rec_pack.sv
module canrx_rec_pack
  import canrx_pkg::*;
(
  input  logic            ext,
  input  logic            rtr,
  input  logic [3:0]      dlc,
  input  logic [28:0]     id,
  input  logic [63:0]     data,
  output rec_t            rec,
  output logic [LENW-1:0] len
);

  logic [7:0]      info;
  logic [LENW-1:0] nhdr;
  logic [LENW-1:0] ndata;

  always_comb begin
    info  = {ext, rtr, 2'b00, dlc};
    len   = rec_len_f(info);
    nhdr  = ext ? LENW'(HDR_EXT) : LENW'(HDR_STD);
    ndata = len - nhdr;
    rec   = '0;
    rec[0] = info;
    if (ext) begin
      rec[1] = id[28:21];
      rec[2] = id[20:13];
      rec[3] = id[12:5];
      rec[4] = {id[4:0], 3'b000};
    end else begin
      rec[1] = id[10:3];
      rec[2] = {id[2:0], 5'b00000};
    end
    for (int j = 0; j < DATA_MAX; j++) begin
      if (LENW'(j) < ndata)
        rec[int'(nhdr) + j] = data[8*j +: 8];
    end
  end

endmodule

// File: rtl/canrx_byte_store.sv
module canrx_byte_store #(
  parameter  int DEPTH = 64,
  localparam int PTRW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PTRW-1:0] waddr,
  input  logic [7:0]      wdata,
  input  logic [PTRW-1:0] raddr_a,
  output logic [7:0]      rdata_a,
  input  logic [PTRW-1:0] raddr_b,
  output logic [7:0]      rdata_b
);

  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic       cell_en;
    logic [7:0] cell_q;
    assign cell_en = we && (waddr == PTRW'(g));
    always_ff @(posedge clk) begin
      if (cell_en)
        cell_q <= wdata;
    end
    assign cells[g] = cell_q;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/canrx_fifo_ctrl.sv
module canrx_fifo_ctrl
  import canrx_pkg::*;
#(
  parameter  int SIZE = 64,
  localparam int PTRW = $clog2(SIZE),
  localparam int CNTW = $clog2(SIZE + 1)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            op_mode,
  input  logic            frm_valid,
  output logic            frm_ready,
  input  rec_t            rec_in,
  input  logic [LENW-1:0] rec_len_in,
  input  logic [7:0]      head_byte,
  input  logic            rel_cmd,
  input  logic            clr_ovr,
  output logic            we,
  output logic [PTRW-1:0] waddr,
  output logic [7:0]      wdata,
  output logic [PTRW-1:0] start_ptr,
  output logic [CNTW-1:0] byte_cnt,
  output logic [CNTW-1:0] msg_cnt,
  output logic            rx_sts,
  output logic            ovr_sts,
  output logic            busy
);

  localparam int SUMW = CNTW + 1;

  logic            busy_q, busy_n;
  logic [LENW-1:0] idx_q, idx_n;
  logic [LENW-1:0] len_q;
  rec_t            hold_q;
  logic [PTRW-1:0] wr_q, wr_n;
  logic [PTRW-1:0] start_q, start_n;
  logic [CNTW-1:0] bcnt_q, bcnt_n;
  logic [CNTW-1:0] mcnt_q, mcnt_n;
  logic            rx_q, rx_n;
  logic            ovr_q, ovr_n;
  logic            op_q;

  logic            accept, ovf, store, commit, leave, rel_ok;
  logic [SUMW-1:0] need;
  logic [LENW-1:0] head_len;

  always_comb begin
    frm_ready = op_mode && !busy_q;
    accept    = frm_valid && frm_ready;
    need      = SUMW'(bcnt_q) + SUMW'(rec_len_in);
    ovf       = need > SUMW'(SIZE);
    store     = accept && !ovf;
    leave     = op_mode && !op_q;
    commit    = busy_q && op_mode && (idx_q == len_q - LENW'(1));
    head_len  = rec_len_f(head_byte);
    rel_ok    = rel_cmd && (mcnt_q != '0) && !leave;
    we        = busy_q && op_mode;
    waddr     = wr_q + PTRW'(idx_q);
    wdata     = hold_q[idx_q];
  end

  // next-state
  always_comb begin
    busy_n  = busy_q;
    idx_n   = idx_q;
    wr_n    = wr_q;
    start_n = start_q;
    bcnt_n  = bcnt_q;
    mcnt_n  = mcnt_q;
    rx_n    = rx_q;
    ovr_n   = ovr_q;

    if (!op_mode)
      busy_n = 1'b0;
    else if (store)
      busy_n = 1'b1;
    else if (commit)
      busy_n = 1'b0;

    if (store)
      idx_n = '0;
    else if (busy_q && !commit)
      idx_n = idx_q + LENW'(1);

    if (leave) begin
      wr_n   = start_q;
      bcnt_n = '0;
      mcnt_n = '0;
      rx_n   = 1'b0;
    end else begin
      if (commit)
        wr_n = wr_q + PTRW'(len_q);
      if (rel_ok)
        start_n = start_q + PTRW'(head_len);
      bcnt_n = bcnt_q + (commit ? CNTW'(len_q) : '0)
                      - (rel_ok ? CNTW'(head_len) : '0);
      mcnt_n = mcnt_q + (commit ? CNTW'(1) : '0)
                      - (rel_ok ? CNTW'(1) : '0);
      if (commit)
        rx_n = 1'b1;
      else if (rel_ok && mcnt_q == CNTW'(1))
        rx_n = 1'b0;
    end

    if (accept && ovf)
      ovr_n = 1'b1;
    else if (clr_ovr)
      ovr_n = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      wr_q    <= '0;
      start_q <= '0;
      bcnt_q  <= '0;
      mcnt_q  <= '0;
      rx_q    <= 1'b0;
      ovr_q   <= 1'b0;
      op_q    <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      idx_q   <= idx_n;
      wr_q    <= wr_n;
      start_q <= start_n;
      bcnt_q  <= bcnt_n;
      mcnt_q  <= mcnt_n;
      rx_q    <= rx_n;
      ovr_q   <= ovr_n;
      op_q    <= op_mode;
    end
  end

  // record hold register, loaded only on a stored accept
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      hold_q <= '0;
    end else if (store) begin
      len_q  <= rec_len_in;
      hold_q <= rec_in;
    end
  end

  assign start_ptr = start_q;
  assign byte_cnt  = bcnt_q;
  assign msg_cnt   = mcnt_q;
  assign rx_sts    = rx_q;
  assign ovr_sts   = ovr_q;
  assign busy      = busy_q;

  // R9 occupancy never passes the buffer size
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_ni)
    bcnt_q <= CNTW'(SIZE));

  a_r4_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> !frm_ready);

  a_r8_sts_tracks_cnt: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_q == (mcnt_q != '0));

  a_r12_empty_consistent: assert property (@(posedge clk) disable iff (!rst_ni)
    (mcnt_q == '0) |-> (bcnt_q == '0));

  a_r7_release_empty: assert property (@(posedge clk) disable iff (!rst_ni)
    (rel_cmd && mcnt_q == '0 && !commit && !leave) |=> $stable(bcnt_q) && $stable(start_q));

  a_r6_release_pops: assert property (@(posedge clk) disable iff (!rst_ni)
    (rel_ok && !commit) |=> (mcnt_q == $past(mcnt_q) - CNTW'(1)));

  a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && ovf) |=> ovr_q);

  a_r11_no_store_in_reset: assert property (@(posedge clk) disable iff (!rst_ni)
    !op_mode |-> !we && !frm_ready);

endmodule

// File: rtl/canrx_record_fifo.sv
module canrx_record_fifo
  import canrx_pkg::*;
#(
  parameter  int SIZE = 64,
  localparam int PTRW = $clog2(SIZE),
  localparam int CNTW = $clog2(SIZE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_mode,
  input  logic            frm_valid,
  output logic            frm_ready,
  input  logic            frm_ext,
  input  logic            frm_rtr,
  input  logic [3:0]      frm_dlc,
  input  logic [28:0]     frm_id,
  input  logic [63:0]     frm_data,
  input  logic            rel_cmd,
  input  logic            clr_ovr,
  input  logic [4:0]      host_addr,
  output logic [7:0]      host_rdata,
  output logic [CNTW-1:0] byte_cnt,
  output logic [CNTW-1:0] msg_cnt,
  output logic            rx_sts,
  output logic            ovr_sts,
  output logic            rcv_busy,
  output logic            irq
);

  localparam logic [4:0] WIN_LO = 5'd16;
  localparam logic [4:0] WIN_HI = WIN_LO + 5'(REC_MAX - 1);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rec_t            rec;
  logic [LENW-1:0] rec_len;
  logic            we;
  logic [PTRW-1:0] waddr;
  logic [7:0]      wdata;
  logic [PTRW-1:0] start_ptr;
  logic [PTRW-1:0] win_addr;
  logic [7:0]      win_byte;
  logic [7:0]      head_byte;
  logic            win_hit;
  logic [4:0]      win_off;

  canrx_rec_pack u_pack (
    .ext  (frm_ext),
    .rtr  (frm_rtr),
    .dlc  (frm_dlc),
    .id   (frm_id),
    .data (frm_data),
    .rec  (rec),
    .len  (rec_len)
  );

  canrx_fifo_ctrl #(.SIZE(SIZE)) u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .op_mode    (op_mode),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .rec_in     (rec),
    .rec_len_in (rec_len),
    .head_byte  (head_byte),
    .rel_cmd    (rel_cmd),
    .clr_ovr    (clr_ovr),
    .we         (we),
    .waddr      (waddr),
    .wdata      (wdata),
    .start_ptr  (start_ptr),
    .byte_cnt   (byte_cnt),
    .msg_cnt    (msg_cnt),
    .rx_sts     (rx_sts),
    .ovr_sts    (ovr_sts),
    .busy       (rcv_busy)
  );

  always_comb begin
    win_hit  = op_mode && (host_addr >= WIN_LO) && (host_addr <= WIN_HI);
    win_off  = host_addr - WIN_LO;
    win_addr = start_ptr + PTRW'(win_off);
  end

  canrx_byte_store #(.DEPTH(SIZE)) u_store (
    .clk     (clk),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr_a (win_addr),
    .rdata_a (win_byte),
    .raddr_b (start_ptr),
    .rdata_b (head_byte)
  );

  assign host_rdata = win_hit ? win_byte : 8'h00;
  assign irq        = rx_sts | ovr_sts;

  // R5 window is silent outside operating mode
  a_r5_window_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !op_mode |-> host_rdata == 8'h00);

endmodule

// File: tb/canrx_record_fifo_tb.sv
module canrx_record_fifo_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_mode, frm_valid, frm_ready, frm_ext, frm_rtr;
  logic [3:0]  frm_dlc;
  logic [28:0] frm_id;
  logic [63:0] frm_data;
  logic        rel_cmd, clr_ovr;
  logic [4:0]  host_addr;
  logic [7:0]  host_rdata;
  logic [6:0]  byte_cnt, msg_cnt;
  logic        rx_sts, ovr_sts, rcv_busy, irq;

  always #5 clk = ~clk;

  canrx_record_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
    .frm_id(frm_id), .frm_data(frm_data),
    .rel_cmd(rel_cmd), .clr_ovr(clr_ovr),
    .host_addr(host_addr), .host_rdata(host_rdata),
    .byte_cnt(byte_cnt), .msg_cnt(msg_cnt),
    .rx_sts(rx_sts), .ovr_sts(ovr_sts), .rcv_busy(rcv_busy), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  int m_buf [64];
  int m_start = 0, m_wr = 0, m_bcnt = 0, m_mcnt = 0;
  bit m_ovr = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int len_of(input int info);
    int nd;
    nd = (info & 64) ? 0 : (((info & 15) > 8) ? 8 : (info & 15));
    return ((info & 128) ? 5 : 3) + nd;
  endfunction

  task automatic check_state(input string req);
    check({req, " byte count"}, int'(byte_cnt), m_bcnt);
    check({req, " message count"}, int'(msg_cnt), m_mcnt);
    check({req, " rx status"}, int'(rx_sts), (m_mcnt != 0) ? 1 : 0);
    check({req, " overrun"}, int'(ovr_sts), int'(m_ovr));
    check({req, " irq"}, int'(irq), ((m_mcnt != 0) || m_ovr) ? 1 : 0);
  endtask

  task automatic check_window(input string req);
    for (int k = 0; k < 13; k++) begin
      if (k < m_bcnt) begin
        host_addr = 5'(16 + k);
        #1;
        check(req, int'(host_rdata), m_buf[(m_start + k) % 64]);
      end
    end
    host_addr = 5'd29;
    #1;
    check("R5 outside window", int'(host_rdata), 0);
    host_addr = 5'd0;
  endtask

  task automatic send(input bit ext, input bit rtr, input int dlc, input int id, input logic [63:0] dat);
    int r [13];
    int len, nd, hdr, cyc, guard;
    guard = 0;
    while (!frm_ready && guard < 50) begin @(negedge clk); guard++; end
    hdr = ext ? 5 : 3;
    nd  = rtr ? 0 : ((dlc > 8) ? 8 : dlc);
    len = hdr + nd;
    r[0] = (ext ? 128 : 0) + (rtr ? 64 : 0) + dlc;
    if (ext) begin
      r[1] = (id >> 21) & 255; r[2] = (id >> 13) & 255;
      r[3] = (id >> 5) & 255;  r[4] = (id & 31) << 3;
    end else begin
      r[1] = (id >> 3) & 255;  r[2] = (id & 7) << 5;
    end
    for (int i = 0; i < nd; i++) r[hdr + i] = int'(dat[8*i +: 8]);
    frm_valid = 1; frm_ext = ext; frm_rtr = rtr; frm_dlc = 4'(dlc);
    frm_id = 29'(id); frm_data = dat;
    @(posedge clk);
    @(negedge clk);
    frm_valid = 0;
    if (m_bcnt + len > 64) begin
      m_ovr = 1;
      check("R9 overrun drops frame, busy", int'(rcv_busy), 0);
      check_state("R9 overrun");
    end else begin
      check("R4 ready low while writing", int'(frm_ready), 0);
      cyc = 0;
      while (rcv_busy && cyc < 20) begin cyc++; @(negedge clk); end
      check(ext ? "R3 R2 write cycles" : "R3 R1 write cycles", cyc, len);
      for (int i = 0; i < len; i++) m_buf[(m_wr + i) % 64] = r[i];
      m_wr = (m_wr + len) % 64;
      m_bcnt += len; m_mcnt++;
      check_state("R4 R8 after store");
    end
  endtask

  task automatic release_one(input string req);
    int l;
    rel_cmd = 1;
    @(posedge clk);
    @(negedge clk);
    rel_cmd = 0;
    if (m_mcnt > 0) begin
      l = len_of(m_buf[m_start]);
      m_start = (m_start + l) % 64;
      m_bcnt -= l; m_mcnt--;
    end
    check_state(req);
  endtask

  task automatic clear_overrun();
    clr_ovr = 1;
    @(posedge clk);
    @(negedge clk);
    clr_ovr = 0;
    m_ovr = 0;
    check_state("R10 clear overrun");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int it;
    rst_n = 0; op_mode = 0; frm_valid = 0; frm_ext = 0; frm_rtr = 0;
    frm_dlc = 0; frm_id = 0; frm_data = 0; rel_cmd = 0; clr_ovr = 0; host_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_state("R12 reset");
    check("R12 busy after reset", int'(rcv_busy), 0);
    check("R11 ready low in reset mode", int'(frm_ready), 0);

    op_mode = 1;
    repeat (2) @(negedge clk);
    check("R11 ready in operating mode", int'(frm_ready), 1);
    release_one("R7 release when empty");

    // sweep: format x RTR x DLC, with interleaved releases
    it = 0;
    for (int e = 0; e < 2; e++)
      for (int q = 0; q < 2; q++)
        for (int d = 0; d < 16; d++) begin
          send(e[0], q[0], d, e ? (29'h0ABCDE5 ^ (d << 17) ^ (q << 3)) : (11'h5A3 ^ d ^ (q << 9)),
               64'h0123_4567_89AB_CDEF ^ {8{8'(d * 17 + e * 3)}});
          check_window(e ? "R2 R5 window" : "R1 R5 window");
          if (m_ovr) clear_overrun();
          if (it % 3 == 2) begin
            release_one("R6 release");
            check_window("R6 R5 window after release");
          end
          it++;
        end

    // drain completely, then one extra release
    while (m_mcnt > 0) release_one("R6 R8 drain");
    release_one("R7 release at zero");

    // exact fill to 64 bytes, then overrun
    for (int i = 0; i < 4; i++) send(1, 0, 8, 29'h1F00_0000 + i, 64'hA5A5_0000_0000_0000 + i);
    send(1, 0, 7, 29'h00001234, 64'h77);
    check("R9 exact fill", int'(byte_cnt), 64);
    send(0, 1, 0, 11'h7FF, 64'h0);
    check("R9 overrun when full", int'(ovr_sts), 1);
    check_window("R5 window on full buffer");
    clear_overrun();

    // reset mode: nothing stored; leaving empties the buffer
    op_mode = 0;
    frm_valid = 1; frm_ext = 0; frm_rtr = 0; frm_dlc = 4'd1; frm_id = 29'h12;
    repeat (3) begin
      @(negedge clk);
      check("R11 ready low in reset mode", int'(frm_ready), 0);
    end
    frm_valid = 0;
    check("R11 counts held in reset mode", int'(byte_cnt), 64);
    host_addr = 5'd16;
    #1;
    check("R5 window reads zero in reset mode", int'(host_rdata), 0);
    host_addr = 5'd0;
    op_mode = 1;
    @(negedge clk);
    m_bcnt = 0; m_mcnt = 0; m_wr = m_start;
    check_state("R11 leave reset mode");
    send(0, 0, 2, 11'h321, 64'hBEEF);
    host_addr = 5'd16;
    #1;
    check("R11 R1 record at offset 0", int'(host_rdata), 8'h02);
    check_window("R11 R1 window after leave");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule